// File: doc/BRIEF.md
# Peripheral Register Space Bridge

This block sits between a processor core and the byte-wide registers of its peripherals. It takes one access request at a time and turns it into a register select, a write strobe, read data and, for bit operations, a two-step read-modify-write. Three request families reach the registers. Short-form port instructions carry a port number from 0x00 to 0x3F. Data-space loads and stores carry a full address. Single-bit set, clear and test-and-skip operations carry a port number and a bit index.

The port range and the data range overlap. Port `p` is the same register as data address `p + 0x20`. Above the port range, data addresses 0x60 to 0xFF form an extended group that only loads and stores can reach. Each request family has its own legal region. A request outside that region is answered with an illegal flag and changes no register. Data addresses outside 0x20 to 0xFF are unmapped. They read as zero, drop writes, and are not flagged. The registers are held inside the block and clear on reset.

Top module: `io_space_bridge`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low and every register reads 0x00.
- R2: Operation code on `req_op`: 0 port read, 1 port write, 2 load, 3 store, 4 bit set, 5 bit clear, 6 skip-if-bit-set, 7 skip-if-bit-clear. A port write to a port from 0x00 to 0x3F (value in `req_addr`) stores `req_wdata`. A port read returns the stored byte on `rsp_rdata`. `rsp_valid` is high in the cycle after the accepting clock edge.
- R3: A load or store at data address `a`, for `a` from 0x20 to 0x5F, reaches the same register as port `a - 0x20`. A value written through either address is read back through the other.
- R4: Loads and stores at data addresses 0x60 to 0xFF reach the extended registers. A load or store is never flagged illegal.
- R5: A port read or port write whose `req_addr` is 0x40 or above is answered with `rsp_illegal` high and `rsp_rdata` 0x00, and no register changes.
- R6: A bit set or bit clear at ports 0x00 to 0x1F changes only bit `req_bit` of that register. `busy` is high for exactly one cycle after acceptance. The response follows one cycle later, and its `rsp_rdata` is the byte that was written.
- R7: A skip-if-bit-set test returns bit `req_bit` on `rsp_skip`. A skip-if-bit-clear test returns its inverse. Both answer in one cycle and leave the register unchanged.
- R8: A bit operation (codes 4 to 7) at port 0x20 or above answers in one cycle with `rsp_illegal` high and `rsp_skip` low. `busy` stays low and no register changes.
- R9: A load or store at a data address below 0x20 or at 0x100 and above is not flagged. A load there returns 0x00, and a store there changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; accepted on a clock edge while `busy` is low |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W (16) | Port number or data address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | DATA_W (8) | Write data for port writes and stores |
| busy | output | 1 | Read-modify-write in its write step; new requests are not taken |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_rdata | output | DATA_W (8) | Read data, or the byte written by a bit set or clear |
| rsp_skip | output | 1 | Skip result of a bit test |
| rsp_illegal | output | 1 | Request was outside its family's legal region |

## Verification
The assertions check several rules on every cycle. Each `busy` cycle is exactly one and is followed by a response. A port request beyond 0x3F, or a bit request beyond 0x1F, is always flagged, with zero data or no skip. A load or store is never flagged. No write strobe names a slot outside the register bank. Some behaviour can be shown only by the directed scenarios, because it depends on stored contents: that the two address aliases meet in one register, that a bit operation leaves the other seven bits as they were, that a rejected or unmapped write leaves the bank unchanged, and that skip results follow the stored bit.

// File: rtl/io_bridge_pkg.sv
package io_bridge_pkg;

  typedef enum logic [2:0] {
    OP_PORT_RD = 3'd0,
    OP_PORT_WR = 3'd1,
    OP_LOAD    = 3'd2,
    OP_STORE   = 3'd3,
    OP_BSET    = 3'd4,
    OP_BCLR    = 3'd5,
    OP_SKIPSET = 3'd6,
    OP_SKIPCLR = 3'd7
  } io_op_e;

  typedef struct packed {
    logic hit;
    logic illegal;
    logic wr;
    logic rd;
    logic bitmod;
    logic bittest;
  } acc_class_t;

  function automatic logic op_is_bit(input io_op_e op);
    return (op == OP_BSET) || (op == OP_BCLR) ||
           (op == OP_SKIPSET) || (op == OP_SKIPCLR);
  endfunction

  function automatic logic op_is_port(input io_op_e op);
    return (op == OP_PORT_RD) || (op == OP_PORT_WR);
  endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_bridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 8,
  parameter int STD_PORTS = 64,
  parameter int BIT_PORTS = 32,
  parameter int DATA_OFS  = 32,
  parameter int EXT_END   = 256
) (
  input  io_op_e            op,
  input  logic [ADDR_W-1:0] addr,
  output acc_class_t        cls,
  output logic [IDX_W-1:0]  idx
);

  logic port_ok;
  logic bit_ok;
  logic data_ok;

  always_comb begin
    port_ok = addr < ADDR_W'(STD_PORTS);
    bit_ok  = addr < ADDR_W'(BIT_PORTS);
    data_ok = (addr >= ADDR_W'(DATA_OFS)) && (addr < ADDR_W'(EXT_END));
  end

  always_comb begin
    cls = '0;
    idx = '0;
    unique case (op)
      OP_PORT_RD, OP_PORT_WR: begin
        cls.hit     = port_ok;
        cls.illegal = !port_ok;
        cls.rd      = (op == OP_PORT_RD);
        cls.wr      = (op == OP_PORT_WR);
        idx         = IDX_W'(addr);
      end
      OP_LOAD, OP_STORE: begin
        cls.hit = data_ok;
        cls.rd  = (op == OP_LOAD);
        cls.wr  = (op == OP_STORE);
        idx     = IDX_W'(addr - ADDR_W'(DATA_OFS));
      end
      OP_BSET, OP_BCLR: begin
        cls.hit     = bit_ok;
        cls.illegal = !bit_ok;
        cls.bitmod  = 1'b1;
        idx         = IDX_W'(addr);
      end
      OP_SKIPSET, OP_SKIPCLR: begin
        cls.hit     = bit_ok;
        cls.illegal = !bit_ok;
        cls.bittest = 1'b1;
        idx         = IDX_W'(addr);
      end
      default: begin
        cls = '0;
        idx = '0;
      end
    endcase
  end

endmodule

// File: rtl/io_reg_bank.sv
module io_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 224,
  parameter int IDX_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic [FLAT_W-1:0] flat_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    logic              slot_en;
    logic [DATA_W-1:0] slot_q;

    assign slot_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= wr_data;
      end
    end

    assign flat_q[g*DATA_W +: DATA_W] = slot_q;
  end

  always_comb begin
    if (int'(rd_idx) < NUM_REGS) begin
      rd_data = flat_q[int'(rd_idx)*DATA_W +: DATA_W];
    end else begin
      rd_data = '0;
    end
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NUM_REGS)) else $error("write index out of range"); // R9

endmodule

// File: rtl/io_bit_rmw.sv
module io_bit_rmw #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              set_bit,
  input  logic              test_clear,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              skip_raw,
  output logic              busy,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_byte
);

  typedef enum logic {RMW_IDLE, RMW_WRITE} rmw_state_e;

  rmw_state_e        state_q, state_d;
  logic [DATA_W-1:0] hold_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BIT_W-1:0]  bit_q;
  logic              set_q;
  logic              load_en;
  logic [DATA_W-1:0] mask;

  assign skip_raw = rd_byte[bit_sel] ^ test_clear;
  assign load_en  = start && (state_q == RMW_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RMW_IDLE:  if (start) state_d = RMW_WRITE;
      RMW_WRITE: state_d = RMW_IDLE;
      default:   state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      idx_q  <= '0;
      bit_q  <= '0;
      set_q  <= 1'b0;
    end else if (load_en) begin
      hold_q <= rd_byte;
      idx_q  <= idx;
      bit_q  <= bit_sel;
      set_q  <= set_bit;
    end
  end

  always_comb begin
    mask    = DATA_W'(1) << bit_q;
    busy    = (state_q == RMW_WRITE);
    wr_en   = busy;
    wr_idx  = idx_q;
    wr_byte = set_q ? (hold_q | mask) : (hold_q & ~mask);
  end

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start) else $error("start during write step"); // R6

endmodule

// File: rtl/io_space_bridge.sv
module io_space_bridge
  import io_bridge_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STD_PORTS = 64,
  parameter int BIT_PORTS = 32,
  parameter int DATA_OFS  = 32,
  parameter int EXT_END   = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [2:0]                req_op,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [$clog2(DATA_W)-1:0] req_bit,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      busy,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_skip,
  output logic                      rsp_illegal
);

  localparam int NUM_REGS = EXT_END - DATA_OFS;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BIT_W    = $clog2(DATA_W);

  // reset: asserted at once, released after two clock edges
  logic rst_s1_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_core_n <= rst_s1_q;
    end
  end

  io_op_e            op_in;
  acc_class_t        cls;
  logic [IDX_W-1:0]  dec_idx;
  logic              accept;
  logic              rmw_busy, rmw_wr_en, rmw_start, skip_raw;
  logic [IDX_W-1:0]  rmw_idx;
  logic [DATA_W-1:0] rmw_byte, rd_data;
  logic              bank_wr_en;
  logic [IDX_W-1:0]  bank_wr_idx;
  logic [DATA_W-1:0] bank_wr_data;

  assign op_in = io_op_e'(req_op);

  io_addr_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STD_PORTS(STD_PORTS),
    .BIT_PORTS(BIT_PORTS), .DATA_OFS(DATA_OFS), .EXT_END(EXT_END)
  ) u_dec (
    .op   (op_in),
    .addr (req_addr),
    .cls  (cls),
    .idx  (dec_idx)
  );

  assign accept    = req_valid && !rmw_busy;
  assign rmw_start = accept && cls.hit && cls.bitmod;

  io_bit_rmw #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BIT_W(BIT_W)) u_rmw (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (rmw_start),
    .set_bit    (op_in == OP_BSET),
    .test_clear (op_in == OP_SKIPCLR),
    .bit_sel    (req_bit),
    .idx        (dec_idx),
    .rd_byte    (rd_data),
    .skip_raw   (skip_raw),
    .busy       (rmw_busy),
    .wr_en      (rmw_wr_en),
    .wr_idx     (rmw_idx),
    .wr_byte    (rmw_byte)
  );

  always_comb begin
    bank_wr_en   = rmw_wr_en || (accept && cls.hit && cls.wr);
    bank_wr_idx  = rmw_wr_en ? rmw_idx : dec_idx;
    bank_wr_data = rmw_wr_en ? rmw_byte : req_wdata;
  end

  io_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (bank_wr_en),
    .wr_idx  (bank_wr_idx),
    .wr_data (bank_wr_data),
    .rd_idx  (dec_idx),
    .rd_data (rd_data)
  );

  // response next-state
  logic              valid_d, skip_d, illegal_d;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    valid_d   = rmw_wr_en || (accept && !(cls.hit && cls.bitmod));
    illegal_d = accept && cls.illegal;
    skip_d    = accept && cls.hit && cls.bittest && skip_raw;
    if (rmw_wr_en) begin
      rdata_d = rmw_byte;
    end else if (accept && cls.hit && cls.rd) begin
      rdata_d = rd_data;
    end else begin
      rdata_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_skip    <= 1'b0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= valid_d;
      rsp_rdata   <= rdata_d;
      rsp_skip    <= skip_d;
      rsp_illegal <= illegal_d;
    end
  end

  assign busy = rmw_busy;

  AST_RMW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |=> (rsp_valid && !busy)) else $error("write step not single"); // R6

  AST_PORT_REACH: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && op_is_port(op_in) && (req_addr >= ADDR_W'(STD_PORTS)))
      |=> (rsp_illegal && (rsp_rdata == '0))) else $error("port reach"); // R5

  AST_BIT_REGION: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && op_is_bit(op_in) && (req_addr >= ADDR_W'(BIT_PORTS)))
      |=> (rsp_valid && rsp_illegal && !rsp_skip && !busy)) else $error("bit region"); // R8

  AST_DATA_NEVER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (accept && ((op_in == OP_LOAD) || (op_in == OP_STORE))) |=> !rsp_illegal)
    else $error("load/store flagged"); // R4

  AST_SKIP_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_skip |-> (rsp_valid && !rsp_illegal)) else $error("stray skip"); // R7

endmodule

// File: tb/tb_io_space_bridge.sv
module tb_io_space_bridge;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] K_IN = 3'd0, K_OUT = 3'd1, K_LD = 3'd2, K_ST = 3'd3,
                         K_SET = 3'd4, K_CLR = 3'd5, K_SKS = 3'd6, K_SKC = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [15:0] req_addr;
  logic [2:0]  req_bit;
  logic [7:0]  req_wdata;
  logic        busy, rsp_valid, rsp_skip, rsp_illegal;
  logic [7:0]  rsp_rdata;

  io_space_bridge dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_skip(rsp_skip), .rsp_illegal(rsp_illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] r_data;
  logic       r_skip, r_ill, r_v1, r_busy1, r_v2;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] a,
                       input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_bit = b; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r_v1 = rsp_valid; r_busy1 = busy; r_data = rsp_rdata;
    r_skip = rsp_skip; r_ill = rsp_illegal; r_v2 = 1'b0;
    if (busy) begin
      @(negedge clk);
      r_v2 = rsp_valid; r_data = rsp_rdata; r_ill = rsp_illegal;
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    issue(K_IN, 16'h05, 0, 0);  chk("R1 port 0x05", r_data, 8'h00);
    issue(K_LD, 16'hA0, 0, 0);  chk("R1 data 0xA0", r_data, 8'h00);
  endtask

  task automatic t_port_io();
    issue(K_OUT, 16'h00, 0, 8'h11);
    chk("R2 write response", r_v1, 1);
    issue(K_OUT, 16'h1F, 0, 8'h5C);
    issue(K_OUT, 16'h3F, 0, 8'hE7);
    issue(K_IN, 16'h00, 0, 0); chk("R2 port 0x00", r_data, 8'h11);
    chk("R2 read timing", {r_v1, r_busy1}, 2'b10);
    issue(K_IN, 16'h1F, 0, 0); chk("R2 port 0x1F", r_data, 8'h5C);
    issue(K_IN, 16'h3F, 0, 0); chk("R2 port 0x3F", r_data, 8'hE7);
  endtask

  task automatic t_alias();
    issue(K_ST, 16'h25, 0, 8'h3C);
    issue(K_IN, 16'h05, 0, 0); chk("R3 store->port", r_data, 8'h3C);
    issue(K_OUT, 16'h3A, 0, 8'h96);
    issue(K_LD, 16'h5A, 0, 0); chk("R3 port->load", r_data, 8'h96);
    issue(K_LD, 16'h5F, 0, 0); chk("R3 load 0x5F alias of 0x3F", r_data, 8'hE7);
  endtask

  task automatic t_extended();
    issue(K_ST, 16'h60, 0, 8'hA1);
    chk("R4 store not illegal", r_ill, 0);
    issue(K_ST, 16'hFF, 0, 8'h4B);
    issue(K_LD, 16'h60, 0, 0); chk("R4 ext 0x60", r_data, 8'hA1);
    issue(K_LD, 16'hFF, 0, 0); chk("R4 ext 0xFF", r_data, 8'h4B);
  endtask

  task automatic t_port_reach();
    issue(K_OUT, 16'h40, 0, 8'h77);
    chk("R5 out 0x40 illegal", r_ill, 1);
    issue(K_LD, 16'h60, 0, 0); chk("R5 ext 0x60 untouched", r_data, 8'hA1);
    issue(K_IN, 16'h60, 0, 0);
    chk("R5 in 0x60 illegal", {r_ill, r_data}, {1'b1, 8'h00});
  endtask

  task automatic t_bit_modify();
    issue(K_OUT, 16'h10, 0, 8'h00);
    issue(K_SET, 16'h10, 3'd3, 0);
    chk("R6 set timing", {r_v1, r_busy1, r_v2}, 3'b011);
    chk("R6 set response byte", r_data, 8'h08);
    issue(K_IN, 16'h10, 0, 0); chk("R6 set result", r_data, 8'h08);
    issue(K_OUT, 16'h1F, 0, 8'hFF);
    issue(K_CLR, 16'h1F, 3'd7, 0);
    chk("R6 clear timing", {r_v1, r_busy1, r_v2}, 3'b011);
    issue(K_LD, 16'h3F, 0, 0); chk("R6 clear result 0x1F", r_data, 8'h7F);
    issue(K_SET, 16'h1F, 3'd7, 0);
    issue(K_IN, 16'h1F, 0, 0); chk("R6 set bit7", r_data, 8'hFF);
  endtask

  task automatic t_bit_test();
    issue(K_OUT, 16'h02, 0, 8'hA5);
    issue(K_SKS, 16'h02, 3'd0, 0);
    chk("R7 skip-set bit0", {r_v1, r_busy1, r_skip}, 3'b101);
    issue(K_SKS, 16'h02, 3'd1, 0); chk("R7 skip-set bit1", r_skip, 0);
    issue(K_SKC, 16'h02, 3'd1, 0); chk("R7 skip-clr bit1", r_skip, 1);
    issue(K_SKC, 16'h02, 3'd7, 0); chk("R7 skip-clr bit7", r_skip, 0);
    issue(K_IN, 16'h02, 0, 0); chk("R7 unchanged", r_data, 8'hA5);
  endtask

  task automatic t_bit_reach();
    issue(K_OUT, 16'h20, 0, 8'h00);
    issue(K_SET, 16'h20, 3'd0, 0);
    chk("R8 set 0x20", {r_v1, r_busy1, r_ill}, 3'b101);
    issue(K_LD, 16'h40, 0, 0); chk("R8 0x20 unchanged", r_data, 8'h00);
    issue(K_OUT, 16'h30, 0, 8'hFF);
    issue(K_SKS, 16'h30, 3'd2, 0);
    chk("R8 test 0x30", {r_ill, r_skip}, 2'b10);
  endtask

  task automatic t_unmapped();
    issue(K_ST, 16'h10, 0, 8'h5A);
    chk("R9 low store not flagged", {r_v1, r_ill}, 2'b10);
    issue(K_LD, 16'h10, 0, 0); chk("R9 low load", r_data, 8'h00);
    issue(K_ST, 16'h0100, 0, 8'h99);
    chk("R9 high store not flagged", r_ill, 0);
    issue(K_LD, 16'h0100, 0, 0); chk("R9 high load", r_data, 8'h00);
    issue(K_LD, 16'h20, 0, 0); chk("R9 no wrap to 0x20", r_data, 8'h11);
    issue(K_IN, 16'h10, 0, 0); chk("R9 port 0x10 intact", r_data, 8'h08);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_bit = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_port_io();
    t_alias();
    t_extended();
    t_port_reach();
    t_bit_modify();
    t_bit_test();
    t_bit_reach();
    t_unmapped();
    done = 1;
    summary();
    $finish;
  end

endmodule